// File: doc/BRIEF.md
# Multi-mode GPIO interrupt detector

This block watches a bank of sampled input lines and turns selected changes or levels on them into latched interrupt events. Each line has its own trigger setting, built from three configuration bits: a level-select bit picks edge or level sensing, a polarity bit picks which edge or which level, and a both-edges bit makes edge sensing react to either direction. When a line's trigger fires, its status bit is latched.

The status bits are masked by a per-line enable register and combined into a single interrupt output. Software clears a status bit by writing 1 to it. Edge sensing compares each new input sample, qualified by a sample-valid strobe, with the sample held from the previous strobe. Level sensing looks at the held sample on every clock.

A small register port gives access to the five per-line registers. The port has an address, a write enable, write data and a combinational read data path. One bit of every register belongs to one line, and bit i belongs to line i.

Top module: `gpio_intr_detect`

## Requirements
- R1: With level-select 0 and both-edges 0, a line with polarity 0 latches status on a falling edge (previous sample 1, new sample 0) and a line with polarity 1 latches status on a rising edge; the opposite edge sets nothing.
- R2: With level-select 0 and both-edges 1, a line latches status on a rising or a falling edge, whatever its polarity bit.
- R3: With level-select 1, a line latches status on every clock in which its held sample equals its polarity bit (1 = active high, 0 = active low), so a status bit cleared while the level persists stays set.
- R4: Writing the status register clears every status bit whose write-data bit is 1; bits written 0 keep their value.
- R5: The interrupt output is 1 exactly when some line has both its status bit and its enable bit at 1; status bits latch whether or not the line is enabled.
- R6: After reset all five registers read 0 (every line in falling single-edge mode, all disabled), the interrupt output is 0, and the held sample of every line is 0.
- R7: Edges are detected only in a clock where sample-valid is 1, and a latched status bit stays set until it is cleared by a write.
- R8: If a line's trigger fires in the same clock as a write that clears its status bit, the bit ends that clock set.
- R9: Register addresses: 0 status (write 1 to clear), 1 enable, 2 polarity, 3 level-select, 4 both-edges; addresses 5 to 7 read 0 and writes there change nothing. Status reaches the register port one clock after the strobe that caused an edge event, and one clock after the held sample meets a level condition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | Strobe qualifying a new input sample |
| sampleIn | input | 32 | Sampled input lines, bit i is line i |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Register write enable |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for the addressed register |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The assertions assume that regAddr, regWrEn and sampleValid are free of unknown values after reset and change only between clock edges. They also assume that sampleIn already comes from a clean sampled source, so any difference between two strobes counts as a real edge. The stimulus drives every input on the falling clock edge, holds each write and each strobe for exactly one cycle, and restores a known held sample and a neutral configuration before each scenario. Because of that, every expected status value can be derived from the previous strobe alone.

// File: rtl/gpio_intr_pkg.sv
package gpio_intr_pkg;

  localparam int unsigned REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADDR_STATUS   = 3'd0,
    ADDR_ENABLE   = 3'd1,
    ADDR_POLARITY = 3'd2,
    ADDR_LEVELSEL = 3'd3,
    ADDR_BOTHEDGE = 3'd4
  } regAddrE;

  // strobes from the control to the datapath
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrPolarity;
    logic wrLevelSel;
    logic wrBothEdge;
    logic rdHit;
    logic [REG_ADDR_W-1:0] rdSel;
  } ctrlStrobeT;

endpackage

// File: rtl/gpio_intr_ctrl.sv
module gpio_intr_ctrl
  import gpio_intr_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  output ctrlStrobeT            strobe
);

  logic addrKnown;

  always_comb begin
    addrKnown = (regAddr <= REG_ADDR_W'(ADDR_BOTHEDGE));
    strobe            = '0;
    strobe.rdSel      = regAddr;
    strobe.rdHit      = addrKnown;
    strobe.wrStatus   = regWrEn && (regAddr == REG_ADDR_W'(ADDR_STATUS));
    strobe.wrEnable   = regWrEn && (regAddr == REG_ADDR_W'(ADDR_ENABLE));
    strobe.wrPolarity = regWrEn && (regAddr == REG_ADDR_W'(ADDR_POLARITY));
    strobe.wrLevelSel = regWrEn && (regAddr == REG_ADDR_W'(ADDR_LEVELSEL));
    strobe.wrBothEdge = regWrEn && (regAddr == REG_ADDR_W'(ADDR_BOTHEDGE));
  end

  // R9
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrStatus, strobe.wrEnable, strobe.wrPolarity,
              strobe.wrLevelSel, strobe.wrBothEdge}));

  // R9
  wr_unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdHit |-> !(strobe.wrStatus || strobe.wrEnable || strobe.wrPolarity ||
                        strobe.wrLevelSel || strobe.wrBothEdge));

endmodule

// File: rtl/gpio_intr_line.sv
module gpio_intr_line (
  input  logic clk,
  input  logic rstN,
  input  logic sampleValid,
  input  logic sampleBit,
  input  logic polarity,
  input  logic levelSel,
  input  logic bothEdge,
  input  logic clrReq,
  output logic statusBit
);

  logic heldQ, statusQ;
  logic riseHit, fallHit, edgeHit, levelHit, eventHit;

  always_comb begin
    riseHit  = sampleValid && sampleBit && !heldQ;
    fallHit  = sampleValid && !sampleBit && heldQ;
    edgeHit  = bothEdge ? (riseHit || fallHit) : (polarity ? riseHit : fallHit);
    levelHit = (heldQ == polarity);
    eventHit = levelSel ? levelHit : edgeHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldQ   <= 1'b0;
      statusQ <= 1'b0;
    end else begin
      if (sampleValid) heldQ <= sampleBit;
      statusQ <= eventHit || (statusQ && !clrReq);
    end
  end

  assign statusBit = statusQ;

  // R4
  clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !eventHit) |=> !statusQ);

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventHit |=> statusQ);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !clrReq) |=> statusQ);

  // R7
  no_strobe_no_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!levelSel && !sampleValid && !statusQ) |=> !statusQ);

endmodule

// File: rtl/gpio_intr_datapath.sv
module gpio_intr_datapath
  import gpio_intr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobeT           strobe,
  input  logic                 sampleValid,
  input  logic [NUM_LINES-1:0] sampleIn,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 irqOut
);

  logic [NUM_LINES-1:0] enableQ, polarityQ, levelSelQ, bothEdgeQ;
  logic [NUM_LINES-1:0] statusVec, clrVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ   <= '0;
      polarityQ <= '0;
      levelSelQ <= '0;
      bothEdgeQ <= '0;
    end else begin
      if (strobe.wrEnable)   enableQ   <= regWrData;
      if (strobe.wrPolarity) polarityQ <= regWrData;
      if (strobe.wrLevelSel) levelSelQ <= regWrData;
      if (strobe.wrBothEdge) bothEdgeQ <= regWrData;
    end
  end

  assign clrVec = strobe.wrStatus ? regWrData : '0;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_intr_line u_line (
      .clk        (clk),
      .rstN       (rstN),
      .sampleValid(sampleValid),
      .sampleBit  (sampleIn[i]),
      .polarity   (polarityQ[i]),
      .levelSel   (levelSelQ[i]),
      .bothEdge   (bothEdgeQ[i]),
      .clrReq     (clrVec[i]),
      .statusBit  (statusVec[i])
    );
  end

  always_comb begin
    regRdData = '0;
    if (strobe.rdHit) begin
      unique case (strobe.rdSel)
        REG_ADDR_W'(ADDR_STATUS):   regRdData = statusVec;
        REG_ADDR_W'(ADDR_ENABLE):   regRdData = enableQ;
        REG_ADDR_W'(ADDR_POLARITY): regRdData = polarityQ;
        REG_ADDR_W'(ADDR_LEVELSEL): regRdData = levelSelQ;
        REG_ADDR_W'(ADDR_BOTHEDGE): regRdData = bothEdgeQ;
        default:                    regRdData = '0;
      endcase
    end
  end

  assign irqOut = |(statusVec & enableQ);

  // R5
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableQ == '0) |-> !irqOut);

endmodule

// File: rtl/gpio_intr_detect.sv
module gpio_intr_detect
  import gpio_intr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sampleValid,
  input  logic [NUM_LINES-1:0]  sampleIn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic                  regWrEn,
  input  logic [NUM_LINES-1:0]  regWrData,
  output logic [NUM_LINES-1:0]  regRdData,
  output logic                  irqOut
);

  ctrlStrobeT strobe;

  gpio_intr_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  gpio_intr_datapath #(.NUM_LINES(NUM_LINES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .irqOut     (irqOut)
  );

endmodule

// File: tb/test_gpio_intr_detect.sv
module test_gpio_intr_detect;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [31:0] sampleIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  gpio_intr_detect i_gpio_intr_detect (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic doSample(input logic [31:0] v);
    sampleIn = v; sampleValid = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // neutral config, held sample = base, status cleared
  task automatic neutral(input logic [31:0] base);
    regWrite(3'd3, 32'h0);
    regWrite(3'd2, 32'h0);
    regWrite(3'd4, 32'h0);
    regWrite(3'd1, 32'h0);
    doSample(base);
    regWrite(3'd0, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a < 5; a++) begin
      readReg(a[2:0], d);
      check("R6 reset register", d, 32'h0);
    end
    check("R6 reset irq", {31'b0, irqOut}, 32'h0);
    doSample(32'h0);
    readReg(3'd0, d);
    check("R6 held sample zero gives no falling edge", d, 32'h0);
  endtask

  task automatic t_falling;
    logic [31:0] d;
    neutral(32'h0);
    doSample(32'h0000_00FF);
    readReg(3'd0, d);
    check("R1 falling mode ignores rising", d, 32'h0);
    doSample(32'h0000_000F);
    readReg(3'd0, d);
    check("R1 falling edges latched", d, 32'h0000_00F0);
    check("R5 status without enable keeps irq low", {31'b0, irqOut}, 32'h0);
    regWrite(3'd1, 32'h0000_0010);
    check("R5 enabled status raises irq", {31'b0, irqOut}, 32'h1);
    regWrite(3'd0, 32'h0);
    readReg(3'd0, d);
    check("R4 writing zero keeps status", d, 32'h0000_00F0);
    regWrite(3'd0, 32'h0000_0010);
    readReg(3'd0, d);
    check("R4 write one clears only that bit", d, 32'h0000_00E0);
    check("R5 irq drops after clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    neutral(32'h0000_000F);
    regWrite(3'd2, 32'hFFFF_0000);
    doSample(32'h0003_0000);
    readReg(3'd0, d);
    check("R1 rising upper and falling lower", d, 32'h0003_000F);
    sampleIn = 32'h0;
    idle(3);
    readReg(3'd0, d);
    check("R7 no strobe no edge and status sticky", d, 32'h0003_000F);
  endtask

  task automatic t_both;
    logic [31:0] d;
    neutral(32'h0000_0000);
    regWrite(3'd4, 32'h0000_0003);
    regWrite(3'd2, 32'h0000_0002);
    doSample(32'h0000_0003);
    readReg(3'd0, d);
    check("R2 both edges rising", d, 32'h0000_0003);
    regWrite(3'd0, 32'h0000_0003);
    doSample(32'h0000_0000);
    readReg(3'd0, d);
    check("R2 both edges falling", d, 32'h0000_0003);
  endtask

  task automatic t_level;
    logic [31:0] d;
    neutral(32'h0000_0200);
    regWrite(3'd2, 32'h0000_0300);
    regWrite(3'd3, 32'h0000_0100);
    idle(1);
    readReg(3'd0, d);
    check("R3 level high absent", d, 32'h0);
    doSample(32'h0000_0300);
    idle(1);
    readReg(3'd0, d);
    check("R3 level high latched", d, 32'h0000_0100);
    regWrite(3'd0, 32'h0000_0100);
    readReg(3'd0, d);
    check("R3 level persists after clear", d, 32'h0000_0100);
    doSample(32'h0000_0200);
    regWrite(3'd0, 32'h0000_0100);
    readReg(3'd0, d);
    check("R3 level gone clears", d, 32'h0);
    regWrite(3'd2, 32'h0);
    idle(1);
    readReg(3'd0, d);
    check("R3 active low latched on held zero", d, 32'h0000_0100);
  endtask

  task automatic t_race;
    logic [31:0] d;
    neutral(32'h0000_0004);
    regWrite(3'd1, 32'h0000_0004);
    sampleIn = 32'h0; sampleValid = 1'b1;
    regAddr = 3'd0; regWrData = 32'h0000_0004; regWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    sampleValid = 1'b0; regWrEn = 1'b0; regWrData = '0;
    readReg(3'd0, d);
    check("R8 event wins over clear", d, 32'h0000_0004);
    check("R8 irq stays high", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic t_map;
    logic [31:0] d;
    neutral(32'h0);
    regWrite(3'd1, 32'hA5A5_0001);
    regWrite(3'd5, 32'hFFFF_FFFF);
    regWrite(3'd7, 32'hFFFF_FFFF);
    readReg(3'd1, d);
    check("R9 enable readback", d, 32'hA5A5_0001);
    readReg(3'd6, d);
    check("R9 unmapped reads zero", d, 32'h0);
    for (int a = 2; a < 5; a++) begin
      readReg(a[2:0], d);
      check("R9 unmapped write changes nothing", d, 32'h0);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    t_reset;
    t_falling;
    t_rising;
    t_both;
    t_level;
    t_race;
    t_map;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule